// File: doc/BRIEF.md
# Bit-Sliced Arithmetic/Logic Unit with Status Flags

This block is a purely combinational arithmetic/logic unit for a small datapath. It is built by repeating one 1-bit stage once per bit. Each stage holds two parts. The arithmetic part is a full adder whose second operand can be zero, the B bit, the inverted B bit or a constant one. The logic part performs one bitwise operation. The top select bit chooses which of the two results leaves the stage. The carry enters at the least significant stage and ripples upward through every stage.

Every arithmetic operation comes from the one adder plus the carry input. The operations are transfer, increment, add, add-with-carry, subtract, ones'-complement add, decrement and transfer-through-decrement. Three status flags describe each result: signed overflow, all-zero and negative. The default width is four bits, and the width is a parameter.

Top module: `bitslice_alu`

## Requirements
- R1: With fsel = 3'b000 the result is opa + carry_in, taken modulo 2^WIDTH (transfer, or increment when carry_in is 1).
- R2: With fsel = 3'b001 the result is opa + opb + carry_in, taken modulo 2^WIDTH.
- R3: With fsel = 3'b010 the result is opa + ~opb + carry_in, taken modulo 2^WIDTH. With carry_in = 1 this equals opa - opb.
- R4: With fsel = 3'b011 the result is opa + all-ones + carry_in, taken modulo 2^WIDTH (decrement, or transfer when carry_in is 1).
- R5: With fsel = 3'b100 the result is opa XOR opb. For example, opa = 3 and opb = 7 give 4.
- R6: With fsel = 3'b101 the result is opa OR opb.
- R7: With fsel = 3'b110 the result is opa AND opb.
- R8: With fsel = 3'b111 the result is the bitwise inverse of opa.
- R9: For fsel[2] = 0, ovf_flag is 1 exactly when the adder's two operands share a sign bit and the result's sign bit differs from it. This is two's-complement overflow. For fsel[2] = 1, ovf_flag is 0.
- R10: zero_flag is 1 exactly when every bit of result is 0.
- R11: neg_flag equals the most significant bit of result.
- R12: For fsel[2] = 1, carry_in has no effect on result or on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (4) | First operand |
| opb | input | WIDTH (4) | Second operand |
| fsel | input | 3 | Function select: bit 2 chooses logic (1) or arithmetic (0); bits 1:0 choose the operation |
| carry_in | input | 1 | Carry into the least significant stage |
| result | output | WIDTH (4) | Operation result |
| ovf_flag | output | 1 | Signed overflow of an arithmetic operation |
| zero_flag | output | 1 | Result is all zeros |
| neg_flag | output | 1 | Result sign bit |

## Verification
A short table of hand-worked cases is run first. It covers the XOR example, both directions of signed overflow, a subtraction that lands on zero, and the wrap from all-ones to zero. These separate correct operand selection from a swapped encoding, and a true overflow rule from a plain carry-out. The bench then sweeps every combination of operands, function and carry input against an independent reference. That sweep exposes any single broken stage, any wrong carry link in the ripple chain, and any flag that depends on the wrong bit. Paired logic-mode cases that differ only in carry_in confirm that the carry is ignored there.

// File: rtl/alu_slice_pkg.sv
`timescale 1ns/1ps
package alu_slice_pkg;

   // Second adder operand chosen by the low function-select bits
   typedef enum logic [1:0] {
      YSEL_ZERO = 2'b00,
      YSEL_B    = 2'b01,
      YSEL_NB   = 2'b10,
      YSEL_ONES = 2'b11
   } ysel_e;

   // Bitwise operation chosen by the low function-select bits
   typedef enum logic [1:0] {
      LOP_XOR  = 2'b00,
      LOP_OR   = 2'b01,
      LOP_AND  = 2'b10,
      LOP_NOTA = 2'b11
   } lop_e;

   typedef struct packed {
      logic       logic_mode;
      logic [1:0] code;
   } fsel_t;

endpackage

// File: rtl/alu_arith_bit.sv
`timescale 1ns/1ps
module alu_arith_bit
   import alu_slice_pkg::*;
(
   input  logic  a,
   input  logic  b,
   input  logic  cin,
   input  ysel_e ysel,
   output logic  y,
   output logic  sum,
   output logic  cout
);

   always_comb begin
      unique case (ysel)
         YSEL_ZERO: y = 1'b0;
         YSEL_B:    y = b;
         YSEL_NB:   y = ~b;
         default:   y = 1'b1;
      endcase
   end

   assign sum  = a ^ y ^ cin;
   assign cout = (a & y) | (cin & (a ^ y));

   // adding a zero operand never generates a carry on its own
   always_comb begin
      if (ysel == YSEL_ZERO)
         p_zero_y_no_gen_r1: assert (cout == (a & cin))
            else $error("zero operand generated a carry");
   end

endmodule

// File: rtl/alu_logic_bit.sv
`timescale 1ns/1ps
module alu_logic_bit
   import alu_slice_pkg::*;
(
   input  logic a,
   input  logic b,
   input  lop_e op,
   output logic r
);

   always_comb begin
      unique case (op)
         LOP_XOR: r = a ^ b;
         LOP_OR:  r = a | b;
         LOP_AND: r = a & b;
         default: r = ~a;
      endcase
   end

endmodule

// File: rtl/alu_stage.sv
`timescale 1ns/1ps
module alu_stage
   import alu_slice_pkg::*;
(
   input  logic  a,
   input  logic  b,
   input  logic  cin,
   input  fsel_t fsel,
   output logic  y,
   output logic  g,
   output logic  cout
);

   logic sum_bit;
   logic log_bit;

   alu_arith_bit u_arith (
      .a    (a),
      .b    (b),
      .cin  (cin),
      .ysel (ysel_e'(fsel.code)),
      .y    (y),
      .sum  (sum_bit),
      .cout (cout)
   );

   alu_logic_bit u_logic (
      .a  (a),
      .b  (b),
      .op (lop_e'(fsel.code)),
      .r  (log_bit)
   );

   assign g = fsel.logic_mode ? log_bit : sum_bit;

   always_comb begin
      if (fsel == 3'b111)
         p_inv_a_r8: assert (g == ~a)
            else $error("inverse stage mismatch");
      if (fsel == 3'b100)
         p_xor_r5: assert (g == (a != b))
            else $error("xor stage mismatch");
   end

endmodule

// File: rtl/alu_flags.sv
`timescale 1ns/1ps
module alu_flags #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] g,
   input  logic             c_into_msb,
   input  logic             c_out_msb,
   input  logic             logic_mode,
   output logic             ovf,
   output logic             zero,
   output logic             neg
);

   localparam int MSB = WIDTH - 1;

   assign ovf  = ~logic_mode & (c_into_msb ^ c_out_msb);
   assign zero = ~|g;
   assign neg  = g[MSB];

endmodule

// File: rtl/bitslice_alu.sv
`timescale 1ns/1ps
module bitslice_alu
   import alu_slice_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [2:0]       fsel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             ovf_flag,
   output logic             zero_flag,
   output logic             neg_flag
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      initial $fatal(1, "bitslice_alu: WIDTH must be at least 2");
   end

   fsel_t            sel_s;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] yop;

   assign sel_s    = fsel_t'(fsel);
   assign carry[0] = carry_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      alu_stage u_stage (
         .a    (opa[i]),
         .b    (opb[i]),
         .cin  (carry[i]),
         .fsel (sel_s),
         .y    (yop[i]),
         .g    (result[i]),
         .cout (carry[i+1])
      );
   end

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .g          (result),
      .c_into_msb (carry[MSB]),
      .c_out_msb  (carry[WIDTH]),
      .logic_mode (sel_s.logic_mode),
      .ovf        (ovf_flag),
      .zero       (zero_flag),
      .neg        (neg_flag)
   );

   logic [WIDTH-1:0] chk_add;
   logic [WIDTH-1:0] chk_sub;

   always_comb begin
      chk_add = opa + opb + {{(WIDTH-1){1'b0}}, carry_in};
      chk_sub = opa - opb;
      if (fsel == 3'b001)
         p_add_r2: assert (result == chk_add)
            else $error("add mismatch");
      if (fsel == 3'b010 && carry_in)
         p_sub_r3: assert (result == chk_sub)
            else $error("subtract mismatch");
      if (fsel[2])
         p_no_overflow_r9: assert (!ovf_flag)
            else $error("overflow flagged in logic mode");
      if (!fsel[2])
         p_ovf_sign_r9: assert (ovf_flag ==
               ((opa[MSB] == yop[MSB]) && (result[MSB] != opa[MSB])))
            else $error("overflow sign rule broken");
      p_zero_r10: assert (zero_flag == (result == '0))
         else $error("zero flag mismatch");
      p_neg_r11: assert (neg_flag == result[MSB])
         else $error("negative flag mismatch");
   end

endmodule

// File: tb/bitslice_alu_tb.sv
`timescale 1ns/1ps
module bitslice_alu_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] opa, opb;
   logic [2:0] fsel;
   logic       carry_in;
   logic [3:0] result;
   logic       ovf_flag, zero_flag, neg_flag;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bitslice_alu #(.WIDTH(4)) u_dut (
      .opa       (opa),
      .opb       (opb),
      .fsel      (fsel),
      .carry_in  (carry_in),
      .result    (result),
      .ovf_flag  (ovf_flag),
      .zero_flag (zero_flag),
      .neg_flag  (neg_flag)
   );

   // {opa, opb, fsel, carry_in, result, ovf, zero, neg}
   localparam logic [18:0] VEC [9] = '{
      {4'h3, 4'h7, 3'd4, 1'b0, 4'h4, 3'b000},  // R5 example
      {4'h7, 4'h1, 3'd1, 1'b0, 4'h8, 3'b101},  // R2 R9 positive overflow
      {4'h5, 4'h5, 3'd2, 1'b1, 4'h0, 3'b010},  // R3 R10 zero
      {4'h8, 4'h1, 3'd2, 1'b1, 4'h7, 3'b100},  // R3 R9 negative overflow
      {4'h0, 4'h0, 3'd3, 1'b0, 4'hF, 3'b001},  // R4 decrement wraps
      {4'hF, 4'h9, 3'd0, 1'b1, 4'h0, 3'b010},  // R1 increment wraps
      {4'hC, 4'hA, 3'd6, 1'b1, 4'h8, 3'b001},  // R7 R12
      {4'hC, 4'hA, 3'd5, 1'b0, 4'hE, 3'b001},  // R6
      {4'h6, 4'h0, 3'd7, 1'b1, 4'h9, 3'b001}   // R8
   };

   function automatic logic [6:0] model(input logic [3:0] a, input logic [3:0] b,
                                        input logic [2:0] s, input logic c);
      logic [3:0] y, g;
      logic       v;
      v = 1'b0;
      if (!s[2]) begin
         case (s[1:0])
            2'd0: y = 4'h0;
            2'd1: y = b;
            2'd2: y = ~b;
            default: y = 4'hF;
         endcase
         g = a + y + {3'b000, c};
         v = (a[3] == y[3]) && (g[3] != a[3]);
      end else begin
         case (s[1:0])
            2'd0: g = a ^ b;
            2'd1: g = a | b;
            2'd2: g = a & b;
            default: g = ~a;
         endcase
      end
      return {g, v, (g == 4'h0), g[3]};
   endfunction

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: opa=%h opb=%h fsel=%0d cin=%0b actual=%h expected=%h",
                  req, opa, opb, fsel, carry_in, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] a, input logic [3:0] b,
                        input logic [2:0] s, input logic c);
      @(posedge clk);
      opa = a; opb = b; fsel = s; carry_in = c;
      @(negedge clk);
   endtask

   function automatic string op_req(input logic [2:0] s);
      case (s)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   logic [6:0] exp_v;
   logic [3:0] g_c0;
   logic [2:0] f_c0;

   initial begin
      opa = '0; opb = '0; fsel = '0; carry_in = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // all-zero inputs: transfer of zero, R1 R10
      check("R1 R10 idle", {result, ovf_flag, zero_flag, neg_flag}, 7'b0000_010);

      foreach (VEC[i]) begin
         apply(VEC[i][18:15], VEC[i][14:11], VEC[i][10:8], VEC[i][7]);
         check({op_req(VEC[i][10:8]), " table"},
               {result, ovf_flag, zero_flag, neg_flag}, VEC[i][6:0]);
      end

      for (int s = 0; s < 8; s++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               for (int c = 0; c < 2; c++) begin
                  apply(4'(a), 4'(b), 3'(s), 1'(c));
                  exp_v = model(4'(a), 4'(b), 3'(s), 1'(c));
                  check(op_req(3'(s)), {result, 3'b000}, {exp_v[6:3], 3'b000});
                  check("R9",  {6'b0, ovf_flag},  {6'b0, exp_v[2]});
                  check("R10", {6'b0, zero_flag}, {6'b0, exp_v[1]});
                  check("R11", {6'b0, neg_flag},  {6'b0, exp_v[0]});
               end

      // R12: carry_in toggled in logic mode leaves every output unchanged
      for (int s = 4; s < 8; s++) begin
         apply(4'h9, 4'h5, 3'(s), 1'b0);
         g_c0 = result; f_c0 = {ovf_flag, zero_flag, neg_flag};
         apply(4'h9, 4'h5, 3'(s), 1'b1);
         check("R12", {result, ovf_flag, zero_flag, neg_flag}, {g_c0, f_c0});
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule